// File: doc/BRIEF.md
# Byte-Write Transaction Controller

This block runs one byte-write exchange from the reader side of a contactless link. A single-cycle start request captures an address, a data byte, the number of address bits in use and a 4-bit checksum computed elsewhere. The block packs these into one command frame and waits a short guard interval. It then sends the frame least significant bit first by gating the carrier. Each bit opens with a fixed carrier-off pause. The length of the carrier-on time that follows tells a zero from a one.

After the last bit the carrier stays on through a fixed programming interval. The block then samples the tag's reply line once per tag bit period. One high sample means the write succeeded. If none of a bounded number of samples is high, the write has failed. Completion is reported as a one-cycle pulse together with a pass/fail flag. The flag keeps its value until the next transaction is accepted.

One tick equals one clock cycle. All tick counts are parameters: guard 240, pause 30, zero bit 60, one bit 120, programming wait 5400, tag bit period 150, 40 acknowledge samples.

Top module: `tag_write_ctrl`

## Requirements
- R1: While reset is held, the carrier output is high, done is low and ok is low.
- R2: The frame has addrWidth + 13 bits and is sent least significant bit first. Bit 0 is the write command bit (parameter WRITE_CMD, default 0). Bits 1 to addrWidth hold address bits 0 to addrWidth-1. The data byte starts at bit addrWidth+1 and the checksum starts at bit addrWidth+9. Address bits at or above addrWidth are not sent.
- R3: The first carrier-off pause begins exactly GUARD_TICKS cycles after the clock edge that accepts start.
- R4: Each frame bit is PAUSE_TICKS cycles with the carrier low, followed by carrier high up to ZERO_TICKS cycles in total for a 0 or ONE_TICKS cycles in total for a 1. The next bit follows directly.
- R5: After the last bit, the carrier stays high for PROG_TICKS cycles. A high tag reply during this interval has no effect on done, on ok or on the time of completion.
- R6: After the programming interval, the reply line is sampled at the end of each BIT_TICKS-cycle period. Sample m (counted from 0) is taken at the edge PROG_TICKS + (m+1)*BIT_TICKS cycles after the frame ends. The first high sample ends the transaction with ok = 1.
- R7: If ACK_TRIES samples are all low, the transaction ends at sample ACK_TRIES-1 with ok = 0. A reply arriving after that sample is not taken.
- R8: done is high for exactly one cycle, right after the deciding sample. ok is valid in that cycle and holds until the edge that accepts the next start, which clears it.
- R9: A start request while a transaction is in progress is ignored. The frame on the carrier and the completion time do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a transaction when idle |
| addrWidth | input | $clog2(ADDR_MAX+1) | Number of address bits in the frame (1 to ADDR_MAX) |
| addr | input | ADDR_MAX | Target address |
| data | input | 8 | Byte to write |
| crc | input | 4 | Checksum placed at the top of the frame |
| tagIn | input | 1 | Demodulated reply from the tag |
| carrierOn | output | 1 | Carrier enable; low during pauses |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Acknowledge seen in the last transaction |

## Verification
The bench keeps ADDR_MAX at its default of 10 and shortens every tick count: guard 12, pause 3, zero 6, one 12, programming 50, tag bit period 10, 5 acknowledge samples. With these values a full-length 23-bit frame, an acknowledge in the final sample slot, a reply one slot too late and a reply during the programming wait each fit in a few hundred cycles. The timing relations checked against the carrier and the done pulse are the same ones that apply at the full-scale defaults.

// File: rtl/tagwr_pkg.sv
package tagwr_pkg;

  localparam int DATA_BITS = 8;
  localparam int CRC_BITS  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_SEND,
    ST_PROG,
    ST_LISTEN
  } wrState_e;

  // strobes from the sequencer to the frame/result datapath
  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic clrOk;
    logic setOk;
    logic fireDone;
  } wrStrobe_t;

endpackage

// File: rtl/tagwr_datapath.sv
module tagwr_datapath
  import tagwr_pkg::*;
#(
  parameter int ADDR_MAX  = 10,
  parameter int WRITE_CMD = 0,
  parameter int AW_W      = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           stb,
  input  logic [AW_W-1:0]     addrWidth,
  input  logic [ADDR_MAX-1:0] addr,
  input  logic [7:0]          data,
  input  logic [3:0]          crc,
  output logic                curBit,
  output logic                lastBit,
  output logic                done,
  output logic                ok
);

  localparam int FRAME_MAX = ADDR_MAX + 1 + DATA_BITS + CRC_BITS;
  localparam int LEFT_W    = $clog2(FRAME_MAX);

  logic [FRAME_MAX-1:0] packedWord;
  logic [FRAME_MAX-1:0] frameReg;
  logic [LEFT_W-1:0]    bitsLeft;
  logic [LEFT_W-1:0]    lenMinus1;
  logic                 okR;
  logic                 doneR;

  // command bit, masked address, data byte and checksum, low bit first
  always_comb begin
    packedWord    = '0;
    packedWord[0] = WRITE_CMD[0];
    for (int i = 0; i < ADDR_MAX; i++) begin
      if (i < int'(addrWidth)) packedWord[1+i] = addr[i];
    end
    packedWord = packedWord
               | (FRAME_MAX'(data) << (int'(addrWidth) + 1))
               | (FRAME_MAX'(crc)  << (int'(addrWidth) + 1 + DATA_BITS));
  end

  assign lenMinus1 = LEFT_W'(int'(addrWidth) + DATA_BITS + CRC_BITS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      bitsLeft <= '0;
      okR      <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      doneR <= stb.fireDone;
      if (stb.loadFrame) begin
        frameReg <= packedWord;
        bitsLeft <= lenMinus1;
      end else if (stb.shiftBit) begin
        frameReg <= frameReg >> 1;
        bitsLeft <= bitsLeft - 1'b1;
      end
      if (stb.clrOk)      okR <= 1'b0;
      else if (stb.setOk) okR <= 1'b1;
    end
  end

  assign curBit  = frameReg[0];
  assign lastBit = (bitsLeft == '0);
  assign done    = doneR;
  assign ok      = okR;

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);

  // R8: the result flag only moves at completion or when a start is accepted
  p_ok_moves_r8: assert property (@(posedge clk) disable iff (!rstN)
    (okR != $past(okR)) |-> (doneR || $past(stb.clrOk)));

  // R2: no shift beyond the last frame bit
  p_shift_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftBit |-> (bitsLeft != '0));

endmodule

// File: rtl/tagwr_ctrl.sv
module tagwr_ctrl
  import tagwr_pkg::*;
#(
  parameter int GUARD_TICKS = 240,
  parameter int PAUSE_TICKS = 30,
  parameter int ZERO_TICKS  = 60,
  parameter int ONE_TICKS   = 120,
  parameter int PROG_TICKS  = 5400,
  parameter int BIT_TICKS   = 150,
  parameter int ACK_TRIES   = 40
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      tagIn,
  input  logic      curBit,
  input  logic      lastBit,
  output wrStrobe_t stb,
  output logic      carrierOn
);

  localparam int MAX_A   = (GUARD_TICKS > PROG_TICKS) ? GUARD_TICKS : PROG_TICKS;
  localparam int MAX_B   = (MAX_A > BIT_TICKS) ? MAX_A : BIT_TICKS;
  localparam int CNT_MAX = (MAX_B > ONE_TICKS) ? MAX_B : ONE_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int TRY_W   = $clog2(ACK_TRIES + 1);

  wrState_e          state, stateNx;
  logic [CNT_W-1:0]  tick, tickNx;
  logic [TRY_W-1:0]  tries, triesNx;
  logic [CNT_W-1:0]  bitEnd;

  assign bitEnd = curBit ? CNT_W'(ONE_TICKS - 1) : CNT_W'(ZERO_TICKS - 1);

  always_comb begin
    stateNx = state;
    tickNx  = tick + 1'b1;
    triesNx = tries;
    stb     = '0;
    case (state)
      ST_IDLE: begin
        tickNx = '0;
        if (start) begin
          stateNx       = ST_GUARD;
          stb.loadFrame = 1'b1;
          stb.clrOk     = 1'b1;
          triesNx       = '0;
        end
      end
      ST_GUARD: begin
        if (tick == CNT_W'(GUARD_TICKS - 1)) begin
          stateNx = ST_SEND;
          tickNx  = '0;
        end
      end
      ST_SEND: begin
        if (tick == bitEnd) begin
          tickNx = '0;
          if (lastBit) stateNx = ST_PROG;
          else         stb.shiftBit = 1'b1;
        end
      end
      ST_PROG: begin
        if (tick == CNT_W'(PROG_TICKS - 1)) begin
          stateNx = ST_LISTEN;
          tickNx  = '0;
          triesNx = '0;
        end
      end
      ST_LISTEN: begin
        if (tick == CNT_W'(BIT_TICKS - 1)) begin
          tickNx = '0;
          if (tagIn) begin
            stb.setOk    = 1'b1;
            stb.fireDone = 1'b1;
            stateNx      = ST_IDLE;
          end else if (tries == TRY_W'(ACK_TRIES - 1)) begin
            stb.fireDone = 1'b1;
            stateNx      = ST_IDLE;
          end else begin
            triesNx = tries + 1'b1;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tick  <= '0;
      tries <= '0;
    end else begin
      state <= stateNx;
      tick  <= tickNx;
      tries <= triesNx;
    end
  end

  assign carrierOn = !((state == ST_SEND) && (tick < CNT_W'(PAUSE_TICKS)));

  // R9: once past the guard, nothing re-enters the guard before idle
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND || state == ST_PROG || state == ST_LISTEN) |=> (state != ST_GUARD));

  // R4: every pause opens at the start of a bit slot
  p_pause_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(carrierOn) |-> (state == ST_SEND && tick == '0));

  // R4: no bit slot runs longer than a one
  p_bit_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) |-> (tick <= CNT_W'(ONE_TICKS - 1)));

  // R5: the programming wait keeps the carrier up and never completes
  p_prog_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG) |-> (carrierOn && !stb.fireDone));

  // R7: the sample counter never passes the try limit
  p_tries_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    tries < TRY_W'(ACK_TRIES));

endmodule

// File: rtl/tag_write_ctrl.sv
module tag_write_ctrl
  import tagwr_pkg::*;
#(
  parameter int ADDR_MAX    = 10,
  parameter int WRITE_CMD   = 0,
  parameter int GUARD_TICKS = 240,
  parameter int PAUSE_TICKS = 30,
  parameter int ZERO_TICKS  = 60,
  parameter int ONE_TICKS   = 120,
  parameter int PROG_TICKS  = 5400,
  parameter int BIT_TICKS   = 150,
  parameter int ACK_TRIES   = 40,
  localparam int AW_W       = $clog2(ADDR_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [AW_W-1:0]     addrWidth,
  input  logic [ADDR_MAX-1:0] addr,
  input  logic [7:0]          data,
  input  logic [3:0]          crc,
  input  logic                tagIn,
  output logic                carrierOn,
  output logic                done,
  output logic                ok
);

  wrStrobe_t stb;
  logic      curBit;
  logic      lastBit;

  tagwr_ctrl #(
    .GUARD_TICKS(GUARD_TICKS),
    .PAUSE_TICKS(PAUSE_TICKS),
    .ZERO_TICKS (ZERO_TICKS),
    .ONE_TICKS  (ONE_TICKS),
    .PROG_TICKS (PROG_TICKS),
    .BIT_TICKS  (BIT_TICKS),
    .ACK_TRIES  (ACK_TRIES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tagIn    (tagIn),
    .curBit   (curBit),
    .lastBit  (lastBit),
    .stb      (stb),
    .carrierOn(carrierOn)
  );

  tagwr_datapath #(
    .ADDR_MAX (ADDR_MAX),
    .WRITE_CMD(WRITE_CMD),
    .AW_W     (AW_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addrWidth(addrWidth),
    .addr     (addr),
    .data     (data),
    .crc      (crc),
    .curBit   (curBit),
    .lastBit  (lastBit),
    .done     (done),
    .ok       (ok)
  );

endmodule

// File: tb/tag_write_ctrl_tb.sv
module tag_write_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_MAX   = 10;
  localparam int WRITE_CMD  = 0;
  localparam int GUARD      = 12;
  localparam int PAUSE      = 3;
  localparam int ZERO       = 6;
  localparam int ONE        = 12;
  localparam int PROG       = 50;
  localparam int BITP       = 10;
  localparam int TRIES      = 5;
  localparam int AW_W       = $clog2(ADDR_MAX + 1);
  localparam int WATCHDOG   = 50000;

  typedef struct packed {
    int aw; int addr; int data; int crc; int slot; int noise; int restart;
  } vec_t;

  // slot: sample index where the tag answers (-1 none; >= TRIES too late)
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8,  'h05A, 'hC3, 'h9, 0,  0, 0},
    '{10, 'h3FF, 'hFF, 'hF, 2,  0, 0},
    '{1,  'h3FE, 'h00, 'h0, -1, 0, 0},
    '{6,  'h2AB, 'hA5, 'h6, 4,  1, 0},
    '{9,  'h155, 'h3C, 'h1, 1,  0, 1},
    '{3,  'h007, 'h81, 'hA, 5,  1, 1}
  };

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic [AW_W-1:0]     awIn = '0;
  logic [ADDR_MAX-1:0] addrIn = '0;
  logic [7:0]          dataIn = '0;
  logic [3:0]          crcIn = '0;
  logic                tagIn = 1'b0;
  logic                carrierOn, done, ok;

  int cyc = 0;
  int nChecks = 0;
  int nErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tag_write_ctrl #(
    .ADDR_MAX(ADDR_MAX), .WRITE_CMD(WRITE_CMD), .GUARD_TICKS(GUARD),
    .PAUSE_TICKS(PAUSE), .ZERO_TICKS(ZERO), .ONE_TICKS(ONE),
    .PROG_TICKS(PROG), .BIT_TICKS(BITP), .ACK_TRIES(TRIES)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .addrWidth(awIn), .addr(addrIn),
    .data(dataIn), .crc(crcIn), .tagIn(tagIn), .carrierOn(carrierOn),
    .done(done), .ok(ok)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!cond) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runXact(input int aw, input int addr, input int data, input int crc,
                         input int slot, input int noise, input int restart);
    longint word;
    int n, k, sendEnd, ackStart, doneExp, m, mism, doneCnt, doneAt;
    bit okExp, okAtDone;
    int off [0:31];
    word = longint'(WRITE_CMD & 1)
         | (longint'(addr & ((1 << aw) - 1)) << 1)
         | (longint'(data) << (aw + 1))
         | (longint'(crc) << (aw + 9));
    n = aw + 13;
    off[0] = 0;
    for (int i = 0; i < n; i++) off[i+1] = off[i] + (word[i] ? ONE : ZERO);

    @(negedge clk);
    start  = 1'b1;
    awIn   = AW_W'(aw);
    addrIn = ADDR_MAX'(addr);
    dataIn = 8'(data);
    crcIn  = 4'(crc);
    k = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    check(ok == 1'b0 && done == 1'b0, "R8", "ok cleared by accepted start", ok, 0);

    sendEnd  = k + GUARD + off[n];
    ackStart = sendEnd + PROG;
    okExp    = (slot >= 0 && slot < TRIES);
    m        = okExp ? slot : TRIES - 1;
    doneExp  = ackStart + (m + 1) * BITP;
    mism = 0; doneCnt = 0; doneAt = -1; okAtDone = 1'b0;

    if (restart != 0) begin
      awIn   = AW_W'(ADDR_MAX);
      addrIn = ~ADDR_MAX'(addr);
      dataIn = ~8'(data);
      crcIn  = ~4'(crc);
    end

    while (cyc <= doneExp + 3) begin
      int c = cyc;
      bit expCar = 1'b1;
      for (int i = 0; i < n; i++)
        if (c >= k + GUARD + off[i] && c < k + GUARD + off[i] + PAUSE) expCar = 1'b0;
      if (carrierOn !== expCar) mism++;
      if (done === 1'b1) begin
        doneCnt++;
        doneAt   = c;
        okAtDone = ok;
      end
      tagIn = ((noise != 0) && c >= sendEnd && c < ackStart) ||
              (slot >= 0 && c >= ackStart + slot * BITP && c < ackStart + (slot + 1) * BITP);
      start = (restart != 0) && (c == k + GUARD + 5);
      @(negedge clk);
    end
    tagIn = 1'b0;
    start = 1'b0;

    check(mism == 0, "R2 R3 R4", "carrier waveform mismatches", mism, 0);
    if (restart != 0) check(mism == 0 && doneAt == doneExp, "R9", "restart while busy changed output", doneAt, doneExp);
    if (noise != 0)   check(doneAt == doneExp, "R5", "reply during programming wait", doneAt, doneExp);
    check(doneCnt == 1, "R8", "done pulse count", doneCnt, 1);
    check(doneAt == doneExp, okExp ? "R6" : "R7", "done cycle", doneAt, doneExp);
    check(okAtDone == okExp, okExp ? "R6" : "R7", "ok at done", okAtDone, okExp);
    repeat (10) @(negedge clk);
    check(ok == okExp && done == 1'b0, "R8", "ok held after done", ok, okExp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(carrierOn == 1'b1, "R1", "carrier in reset", carrierOn, 1);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(ok == 1'b0, "R1", "ok in reset", ok, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // stimulus table
    for (int v = 0; v < NVEC; v++)
      runXact(VECS[v].aw, VECS[v].addr, VECS[v].data, VECS[v].crc,
              VECS[v].slot, VECS[v].noise, VECS[v].restart);

    // directed: success after a failure, then failure after a success (R6 R7)
    runXact(4, 'h00A, 'h5A, 'h3, TRIES - 1, 1, 0);
    runXact(10, 'h201, 'h01, 'h8, -1, 0, 1);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    wait (cyc > WATCHDOG);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule